// File: doc/BRIEF.md
# NAND Command and Address Front End

This block sits behind the pins of a small-page NAND flash device and turns host write cycles into decoded work for the rest of the device. Each rising edge of the write strobe latches one byte from the 8-bit bus. If the command latch enable is high, the byte goes to the command register. If the address latch enable is high, the byte goes into a four-cycle address register. The block decodes command bytes into one-cycle operation request pulses. It reports a completed address, a full column and row address, and a status byte for the host to read.

A small-page page holds 528 bytes: two 256-byte halves plus a spare area. The address cycles carry only the low eight column bits. Which of the three regions is addressed comes from a pointer register, which is set by pointer command bytes. The cell array, the high-voltage sequencing and the busy timing live downstream. Here they appear only as a busy input and an operation-done input with a pass/fail result.

Top module: `nand_fe_latch`

## Requirements
- R1: A byte is taken only on the clock where `wr_stb` is sampled high after being sampled low. Holding `wr_stb` high latches nothing further, whatever the bus does.
- R2: Address bytes latch when `addr_le` is high and `cmd_le` is low. The first byte is column bits 7:0. Bytes two to four are the row address, least significant byte first. `addr_done` pulses for one cycle after the fourth byte. Further address bytes are ignored until the next command.
- R3: `col_addr` depends on the pointer. For pointer 00h it is the column byte itself. For pointer 01h it is 256 plus the column byte. For pointer 50h it is 512 plus the low four bits of the column byte. It never reaches 528.
- R4: After reset, `cmd_reg` is 00h, the pointer selects the first half, `col_addr` and `row_addr` are zero, and no pulse output is high.
- R5: `op_req` pulses for one cycle after a command byte latches, with at most one bit set. The bit positions are: bit 0 for 00h, 01h and 50h (read); bit 1 for 80h (program setup); bit 2 for 60h (erase setup); bit 3 for D0h (erase confirm); bit 4 for 70h (status read); bit 5 for 90h (ID read); bit 6 for FFh (reset). Any other byte is stored in `cmd_reg` but raises no request.
- R6: Command FFh sets `cmd_reg` to 00h, returns the pointer to the first half and clears the fail flag. With `wp_n` high and the device not busy, `status` then reads C0h.
- R7: Command FFh latched while `busy` is high pulses `abort` for one cycle. Latched while not busy, it does not pulse `abort`.
- R8: A byte written with both latch enables high changes no register and pulses `proto_err` for one cycle.
- R9: When `op_done` is seen while the pointer selects the second half, the pointer returns to the first half. The spare pointer is kept across `op_done`.
- R10: `status` bit 7 equals `wp_n`, bit 6 is the inverse of `busy`, and bits 5:1 are zero. Bit 0 is set by `op_done` with `op_pass` low, and is cleared by an 80h, 60h or FFh command.
- R11: Every latched command restarts the address sequence at the column byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, latched on its rising edge |
| cmd_le | input | 1 | Command latch enable |
| addr_le | input | 1 | Address latch enable |
| bus_in | input | 8 | Data bus |
| wp_n | input | 1 | Write protect, high means writable |
| busy | input | 1 | Downstream operation in progress |
| op_done | input | 1 | Downstream operation finished (one cycle) |
| op_pass | input | 1 | Result that goes with op_done |
| cmd_reg | output | 8 | Command register contents |
| op_req | output | 7 | One-hot request pulses |
| abort | output | 1 | Reset issued while busy |
| proto_err | output | 1 | Both latch enables were high |
| addr_done | output | 1 | Final address cycle taken |
| col_addr | output | 10 | Column within the 528-byte page |
| row_addr | output | 24 | Page (row) address |
| status | output | 8 | Status byte |

## Verification
The bench holds the strobe high while the bus changes. A level-sensitive latch would re-capture in that case. It sends a fifth address byte, which a counter without a limit would write over the row. It walks the pointer through 01h, `op_done` and 50h. A design that reset the spare pointer, or that kept the second-half pointer, would show the wrong high column bits. Reset is issued both while busy and while idle, which exposes an `abort` tied to the command alone. The both-enables-high cycle exposes a design that lets either path win.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
   typedef enum logic [1:0] {
      AREA_LO    = 2'd0,
      AREA_HI    = 2'd1,
      AREA_SPARE = 2'd2
   } area_t;

   localparam logic [7:0] C_PTR_LO = 8'h00;
   localparam logic [7:0] C_PTR_HI = 8'h01;
   localparam logic [7:0] C_PTR_SP = 8'h50;
   localparam logic [7:0] C_PROG   = 8'h80;
   localparam logic [7:0] C_ERASE  = 8'h60;
   localparam logic [7:0] C_ERCONF = 8'hD0;
   localparam logic [7:0] C_STAT   = 8'h70;
   localparam logic [7:0] C_ID     = 8'h90;
   localparam logic [7:0] C_RESET  = 8'hFF;

   localparam int REQ_W      = 7;
   localparam int RQ_READ    = 0;
   localparam int RQ_PROG    = 1;
   localparam int RQ_ERASE   = 2;
   localparam int RQ_ERCONF  = 3;
   localparam int RQ_STAT    = 4;
   localparam int RQ_ID      = 5;
   localparam int RQ_RESET   = 6;
endpackage

// File: rtl/nand_fe_strobe.sv
module nand_fe_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_stb,
   input  logic cle,
   input  logic ale,
   output logic cmd_stb,
   output logic addr_stb,
   output logic proto_err
);
   logic wr_q;
   logic rise;

   assign rise     = wr_stb & ~wr_q;
   assign cmd_stb  = rise & cle & ~ale;
   assign addr_stb = rise & ale & ~cle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q      <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         wr_q      <= wr_stb;
         proto_err <= rise & cle & ale;
      end
   end

   // R8
   both_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ($past(cle) && $past(ale)));
endmodule

// File: rtl/nand_fe_addr.sv
module nand_fe_addr
   import nand_fe_pkg::*;
#(
   parameter int ADDR_CYCLES = 4,
   parameter int SPARE_BYTES = 16,
   localparam int ROW_W  = 8 * (ADDR_CYCLES - 1),
   localparam int COL_W  = $clog2(512 + SPARE_BYTES),
   localparam int SP_W   = $clog2(SPARE_BYTES),
   localparam int CNT_W  = $clog2(ADDR_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             addr_stb,
   input  logic             cmd_stb,
   input  logic [7:0]       din,
   input  logic             ptr_wr,
   input  area_t            ptr_sel,
   input  logic             op_done,
   output logic [COL_W-1:0] col_addr,
   output logic [ROW_W-1:0] row_addr,
   output logic             addr_done
);
   logic [CNT_W-1:0] cnt;
   logic [7:0]       col_lo;
   area_t            area;
   logic             take;

   assign take = addr_stb && (cnt < CNT_W'(ADDR_CYCLES));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt       <= '0;
         col_lo    <= '0;
         addr_done <= 1'b0;
      end else begin
         addr_done <= take && (cnt == CNT_W'(ADDR_CYCLES - 1));
         if (cmd_stb) begin
            cnt <= '0;
         end else if (take) begin
            cnt <= cnt + 1'b1;
            if (cnt == '0) col_lo <= din;
         end
      end
   end

   for (genvar b = 0; b < ADDR_CYCLES - 1; b++) begin : g_row
      always_ff @(posedge clk) begin
         if (!rst_n) row_addr[8*b +: 8] <= '0;
         else if (take && !cmd_stb && cnt == CNT_W'(b + 1)) row_addr[8*b +: 8] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) area <= AREA_LO;
      else if (ptr_wr) area <= ptr_sel;
      else if (op_done && area == AREA_HI) area <= AREA_LO;
   end

   always_comb begin
      unique case (area)
         AREA_HI:    col_addr = COL_W'(256) + COL_W'(col_lo);
         AREA_SPARE: col_addr = COL_W'(512) + COL_W'(col_lo[SP_W-1:0]);
         default:    col_addr = COL_W'(col_lo);
      endcase
   end

   // R3
   col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_addr < COL_W'(512 + SPARE_BYTES));
   // R9
   ptr_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !ptr_wr && col_addr >= COL_W'(256) && col_addr < COL_W'(512))
      |=> col_addr < COL_W'(256));
   // R2
   addr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_done |-> $past(addr_stb));
endmodule

// File: rtl/nand_fe_cmd.sv
module nand_fe_cmd
   import nand_fe_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_stb,
   input  logic [7:0]       din,
   input  logic             busy,
   input  logic             wp_n,
   input  logic             op_done,
   input  logic             op_pass,
   output logic [7:0]       cmd_reg,
   output logic [REQ_W-1:0] op_req,
   output logic             abort,
   output logic             ptr_wr,
   output area_t            ptr_sel,
   output logic [7:0]       status
);
   logic [REQ_W-1:0] dec;
   logic             fail_q;

   always_comb begin
      dec     = '0;
      ptr_wr  = 1'b0;
      ptr_sel = AREA_LO;
      unique case (din)
         C_PTR_LO: begin dec[RQ_READ] = 1'b1; ptr_wr = 1'b1; ptr_sel = AREA_LO; end
         C_PTR_HI: begin dec[RQ_READ] = 1'b1; ptr_wr = 1'b1; ptr_sel = AREA_HI; end
         C_PTR_SP: begin dec[RQ_READ] = 1'b1; ptr_wr = 1'b1; ptr_sel = AREA_SPARE; end
         C_PROG:   dec[RQ_PROG]   = 1'b1;
         C_ERASE:  dec[RQ_ERASE]  = 1'b1;
         C_ERCONF: dec[RQ_ERCONF] = 1'b1;
         C_STAT:   dec[RQ_STAT]   = 1'b1;
         C_ID:     dec[RQ_ID]     = 1'b1;
         C_RESET:  begin dec[RQ_RESET] = 1'b1; ptr_wr = 1'b1; ptr_sel = AREA_LO; end
         default:  dec = '0;
      endcase
      if (!cmd_stb) begin
         dec    = '0;
         ptr_wr = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_reg <= C_PTR_LO;
         op_req  <= '0;
         abort   <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         op_req <= dec;
         abort  <= dec[RQ_RESET] & busy;
         if (cmd_stb) cmd_reg <= dec[RQ_RESET] ? 8'h00 : din;
         if (dec[RQ_RESET] || dec[RQ_PROG] || dec[RQ_ERASE]) fail_q <= 1'b0;
         else if (op_done && !op_pass) fail_q <= 1'b1;
      end
   end

   assign status = {wp_n, ~busy, 5'b00000, fail_q};

   // R5
   req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(op_req));
   // R7
   abort_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> op_req[RQ_RESET]);
   // R6
   fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_req[RQ_RESET] |-> (status[0] == 1'b0 && cmd_reg == 8'h00));
endmodule

// File: rtl/nand_fe_latch.sv
module nand_fe_latch
   import nand_fe_pkg::*;
#(
   parameter int ADDR_CYCLES = 4,
   parameter int SPARE_BYTES = 16
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  wr_stb,
   input  logic                                  cmd_le,
   input  logic                                  addr_le,
   input  logic [7:0]                            bus_in,
   input  logic                                  wp_n,
   input  logic                                  busy,
   input  logic                                  op_done,
   input  logic                                  op_pass,
   output logic [7:0]                            cmd_reg,
   output logic [6:0]                            op_req,
   output logic                                  abort,
   output logic                                  proto_err,
   output logic                                  addr_done,
   output logic [$clog2(512 + SPARE_BYTES)-1:0]  col_addr,
   output logic [8*(ADDR_CYCLES-1)-1:0]          row_addr,
   output logic [7:0]                            status
);
   if (ADDR_CYCLES < 2 || ADDR_CYCLES > 5) begin : g_bad_cycles
      $error("ADDR_CYCLES must lie in 2..5");
   end
   if (SPARE_BYTES < 2 || SPARE_BYTES > 128 || (SPARE_BYTES & (SPARE_BYTES - 1)) != 0) begin : g_bad_spare
      $error("SPARE_BYTES must be a power of two in 2..128");
   end

   logic  cmd_stb;
   logic  addr_stb;
   logic  ptr_wr;
   area_t ptr_sel;

   nand_fe_strobe u_stb (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .cle       (cmd_le),
      .ale       (addr_le),
      .cmd_stb   (cmd_stb),
      .addr_stb  (addr_stb),
      .proto_err (proto_err)
   );

   nand_fe_cmd u_cmd (
      .clk     (clk),
      .rst_n   (rst_n),
      .cmd_stb (cmd_stb),
      .din     (bus_in),
      .busy    (busy),
      .wp_n    (wp_n),
      .op_done (op_done),
      .op_pass (op_pass),
      .cmd_reg (cmd_reg),
      .op_req  (op_req),
      .abort   (abort),
      .ptr_wr  (ptr_wr),
      .ptr_sel (ptr_sel),
      .status  (status)
   );

   nand_fe_addr #(
      .ADDR_CYCLES (ADDR_CYCLES),
      .SPARE_BYTES (SPARE_BYTES)
   ) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_stb  (addr_stb),
      .cmd_stb   (cmd_stb),
      .din       (bus_in),
      .ptr_wr    (ptr_wr),
      .ptr_sel   (ptr_sel),
      .op_done   (op_done),
      .col_addr  (col_addr),
      .row_addr  (row_addr),
      .addr_done (addr_done)
   );
endmodule

// File: tb/nand_fe_latch_tb.sv
module nand_fe_latch_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0, cmd_le = 1'b0, addr_le = 1'b0;
   logic [7:0]  bus_in = 8'h00;
   logic        wp_n = 1'b1, busy = 1'b0, op_done = 1'b0, op_pass = 1'b1;
   logic [7:0]  cmd_reg;
   logic [6:0]  op_req;
   logic        abort, proto_err, addr_done;
   logic [9:0]  col_addr;
   logic [23:0] row_addr;
   logic [7:0]  status;

   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;
   logic [6:0] s_req;
   logic       s_err, s_abort, s_done;

   always #(CLK_PERIOD/2) clk = ~clk;

   nand_fe_latch u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .cmd_le(cmd_le), .addr_le(addr_le),
      .bus_in(bus_in), .wp_n(wp_n), .busy(busy), .op_done(op_done), .op_pass(op_pass),
      .cmd_reg(cmd_reg), .op_req(op_req), .abort(abort), .proto_err(proto_err),
      .addr_done(addr_done), .col_addr(col_addr), .row_addr(row_addr), .status(status)
   );

   // {cle, ale, byte, expected op_req, expected proto_err}
   localparam logic [17:0] VEC [10] = '{
      {1'b1, 1'b0, 8'h80, 7'b0000010, 1'b0},
      {1'b1, 1'b0, 8'h60, 7'b0000100, 1'b0},
      {1'b1, 1'b0, 8'hD0, 7'b0001000, 1'b0},
      {1'b1, 1'b0, 8'h70, 7'b0010000, 1'b0},
      {1'b1, 1'b0, 8'h90, 7'b0100000, 1'b0},
      {1'b1, 1'b0, 8'hFF, 7'b1000000, 1'b0},
      {1'b1, 1'b0, 8'h01, 7'b0000001, 1'b0},
      {1'b1, 1'b0, 8'h3C, 7'b0000000, 1'b0},
      {1'b1, 1'b1, 8'hAA, 7'b0000000, 1'b1},
      {1'b0, 1'b0, 8'h55, 7'b0000000, 1'b0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic c, input logic a, input logic [7:0] d);
      @(negedge clk);
      cmd_le = c; addr_le = a; bus_in = d; wr_stb = 1'b1;
      @(negedge clk);
      s_req = op_req; s_err = proto_err; s_abort = abort; s_done = addr_done;
      wr_stb = 1'b0; cmd_le = 1'b0; addr_le = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_done(input logic pass);
      @(negedge clk);
      op_done = 1'b1; op_pass = pass;
      @(negedge clk);
      op_done = 1'b0; op_pass = 1'b1;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0] exp_cmd;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R4 reset state
      chk("R4 cmd_reg", 32'(cmd_reg), 32'h00);
      chk("R4 op_req", 32'(op_req), 32'h0);
      chk("R4 col_addr", 32'(col_addr), 32'h0);
      chk("R4 row_addr", 32'(row_addr), 32'h0);
      chk("R4 pulses", 32'({abort, proto_err, addr_done}), 32'h0);
      chk("R10 status idle", 32'(status), 32'hC0);

      // R5 R8 R6 table walk
      exp_cmd = 8'h00;
      for (int i = 0; i < 10; i++) begin
         wr(VEC[i][17], VEC[i][16], VEC[i][15:8]);
         if (VEC[i][17] && !VEC[i][16]) exp_cmd = (VEC[i][15:8] == 8'hFF) ? 8'h00 : VEC[i][15:8];
         chk($sformatf("R5 req vec%0d", i), 32'(s_req), 32'(VEC[i][7:1]));
         chk($sformatf("R8 err vec%0d", i), 32'(s_err), 32'(VEC[i][0]));
         chk($sformatf("R1 cmd_reg vec%0d", i), 32'(cmd_reg), 32'(exp_cmd));
      end
      chk("R5 req cleared", 32'(op_req), 32'h0);

      // R2 R3 second half address
      wr(1, 0, 8'h01);
      wr(0, 1, 8'h34); chk("R2 no done c1", 32'(s_done), 32'h0);
      wr(0, 1, 8'h11);
      wr(0, 1, 8'h22);
      wr(0, 1, 8'h33); chk("R2 done c4", 32'(s_done), 32'h1);
      chk("R3 col hi", 32'(col_addr), 32'h134);
      chk("R2 row", 32'(row_addr), 32'h332211);
      wr(0, 1, 8'h77);
      chk("R2 extra byte done", 32'(s_done), 32'h0);
      chk("R2 extra byte row", 32'(row_addr), 32'h332211);
      chk("R2 extra byte col", 32'(col_addr), 32'h134);

      // R9 second half reverts
      pulse_done(1'b1);
      chk("R9 hi returns", 32'(col_addr), 32'h034);

      // R3 R9 spare kept
      wr(1, 0, 8'h50);
      chk("R3 col spare", 32'(col_addr), 32'h204);
      pulse_done(1'b1);
      chk("R9 spare kept", 32'(col_addr), 32'h204);
      wr(1, 0, 8'h00);
      chk("R3 col lo", 32'(col_addr), 32'h034);

      // R11 restart on command
      wr(0, 1, 8'h12);
      wr(1, 0, 8'h70);
      wr(0, 1, 8'h56);
      chk("R11 restart col", 32'(col_addr), 32'h056);
      chk("R11 row kept", 32'(row_addr), 32'h332211);

      // R1 strobe held high
      wr(1, 0, 8'h90);
      @(negedge clk);
      cmd_le = 1'b1; bus_in = 8'h80; wr_stb = 1'b1;
      @(negedge clk);
      chk("R1 first edge", 32'(cmd_reg), 32'h80);
      bus_in = 8'h60;
      repeat (3) begin
         @(negedge clk);
         chk("R1 held no req", 32'(op_req), 32'h0);
      end
      chk("R1 held cmd", 32'(cmd_reg), 32'h80);
      wr_stb = 1'b0; cmd_le = 1'b0;
      @(negedge clk);

      // R10 status
      pulse_done(1'b0);
      chk("R10 fail set", 32'(status), 32'hC1);
      busy = 1'b1; @(negedge clk);
      chk("R10 busy bit", 32'(status), 32'h81);
      wp_n = 1'b0; @(negedge clk);
      chk("R10 wp bit", 32'(status), 32'h01);
      wp_n = 1'b1; busy = 1'b0;
      wr(1, 0, 8'h80);
      chk("R10 fail cleared", 32'(status), 32'hC0);

      // R7 R6 reset while busy and idle
      pulse_done(1'b0);
      wr(1, 0, 8'h01);
      busy = 1'b1;
      wr(1, 0, 8'hFF);
      chk("R7 abort busy", 32'(s_abort), 32'h1);
      busy = 1'b0; @(negedge clk);
      chk("R6 status C0", 32'(status), 32'hC0);
      chk("R6 cmd_reg", 32'(cmd_reg), 32'h00);
      chk("R6 pointer lo", 32'(col_addr), 32'h056);
      wr(1, 0, 8'hFF);
      chk("R7 no abort idle", 32'(s_abort), 32'h0);

      finish_run();
   end
endmodule